// File: doc/BRIEF.md
# Four-Neighbour Laplacian Edge Magnitude Pipeline

This block turns a raster stream of 8-bit monochrome pixels into an 8-bit edge-strength image. Pixels are unsigned, with 0 as black and 255 as white. Upstream supplies one vertical triple of pixels per step: the pixel of the current row plus the pixels directly above and below it in the same column. Triples arrive left to right within a row and rows top to bottom. The frame width and height are parameters, and the defaults are 720 by 480.

The block keeps the two most recent triples as the left and centre columns of a 3x3 window. The incoming triple is the right column. For each accepted triple it evaluates only the five non-zero taps of the Laplacian: four times the centre, minus the pixels above, below, left and right. The four corner taps are zero and are never computed. The signed 11-bit result is replaced by its absolute value and clamped to 255.

Each output pixel is centred one column behind the triple that produced it. The output image is therefore shifted right by one column. Any window that touches the frame edge yields 0. Both sides use valid/ready handshakes. A stalled output freezes the whole pipeline and no pixel is lost.

Top module: `lap_edge_top`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Take a triple accepted at column x (counted from 0) of row y, with x of 2 or more and y between 1 and H-2. Its output is |4·c − u − d − l − r|, where c, u and d are the mid, top and bottom pixels of column x−1, l is the mid pixel of column x−2 and r is the mid pixel of column x. This holds whenever that magnitude is 255 or less. A uniform image therefore gives 0.
- R3: When the magnitude of the sum exceeds 255, the output is 255.
- R4: A negative sum yields its positive magnitude, not a wrapped or zero value.
- R5: The output is 0 for triples with x < 2, in row 0 or in row H−1.
- R6: Exactly one output pixel leaves for each accepted triple, in acceptance order.
- R7: Suppose a triple is accepted at a rising edge and the pipeline is free at the next edge. Its result is then presented with `out_valid` high after that next edge.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_pixel` hold and `in_ready` is low.
- R9: The column counter wraps after W triples and the row counter wraps after H rows, so consecutive frames are processed identically without reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Triple on the input is valid |
| in_ready | output | 1 | Block accepts a triple this cycle |
| in_top | input | 8 | Pixel one row above the current row |
| in_mid | input | 8 | Pixel of the current row |
| in_bot | input | 8 | Pixel one row below the current row |
| out_valid | output | 1 | Edge pixel on the output is valid |
| out_ready | input | 1 | Downstream accepts the edge pixel |
| out_pixel | output | 8 | Clamped edge magnitude |

## Verification
A triple accepted at one rising edge fills the sum stage at that edge. It reaches the output register at the following edge, provided the output is free or being drained then. The bench drives and samples on the falling edge. At that point it already knows which handshakes the next rising edge will complete, so each sampled output is matched with the triple two accepting edges back through an ordered index, never a fixed delay. The latency test checks `out_valid` low one falling edge after the accepting edge and high at the falling edge after that. The stall tests compare each held output with the value seen one cycle earlier.

// File: rtl/lap_edge_pkg.sv
package lap_edge_pkg;

    localparam int PIX_W = 8;
    localparam int SUM_W = 11;

    typedef logic [PIX_W-1:0]        pix_t;
    typedef logic signed [SUM_W-1:0] sum_t;

    typedef struct packed {
        pix_t top;
        pix_t mid;
        pix_t bot;
    } column_t;

    typedef struct packed {
        logic valid;
        logic border;
        sum_t d;
    } sum_stage_t;

    localparam sum_t PIX_MAX = sum_t'(255);
    localparam sum_t PIX_MIN = -PIX_MAX;

    function automatic sum_t widen(input pix_t p);
        return sum_t'({{(SUM_W-PIX_W){1'b0}}, p});
    endfunction

    // five-tap Laplacian: corners carry zero weight and are skipped
    function automatic sum_t lap_sum(input column_t l, input column_t c, input column_t r);
        sum_t acc;
        acc = widen(c.mid) <<< 2;
        acc = acc - widen(c.top) - widen(c.bot) - widen(l.mid) - widen(r.mid);
        return acc;
    endfunction

    function automatic pix_t mag_clamp(input sum_t d);
        sum_t a;
        a = (d < 0) ? -d : d;
        return (a > PIX_MAX) ? {PIX_W{1'b1}} : a[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/raster_pos.sv
module raster_pos
    import lap_edge_pkg::*;
#(
    parameter int W = 720,
    parameter int H = 480
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic border
);
    localparam int XW = $clog2(W);
    localparam int YW = $clog2(H);
    localparam logic [XW-1:0] X_LAST = XW'(W - 1);
    localparam logic [YW-1:0] Y_LAST = YW'(H - 1);
    localparam logic [XW-1:0] X_FIRST_IN = XW'(2);

    logic [XW-1:0] x_q;
    logic [YW-1:0] y_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else if (step) begin
            if (x_q == X_LAST) begin
                x_q <= '0;
                y_q <= (y_q == Y_LAST) ? '0 : y_q + 1'b1;
            end else begin
                x_q <= x_q + 1'b1;
            end
        end
    end

    // window centre is one column behind the incoming triple
    assign border = (x_q < X_FIRST_IN) || (y_q == '0) || (y_q == Y_LAST);

    // R9
    x_range_chk: assert property (@(posedge clk) disable iff (rst)
        (x_q <= X_LAST) && (y_q <= Y_LAST));

    // R9
    row_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && x_q == X_LAST && y_q == Y_LAST) |=> (x_q == '0 && y_q == '0));

endmodule

// File: rtl/lap_window.sv
module lap_window
    import lap_edge_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       advance,
    input  column_t    col_in,
    input  logic       border_in,
    output sum_stage_t s1
);
    column_t left_q;
    column_t centre_q;
    logic    accept;

    assign accept = in_valid && advance;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q   <= '0;
            centre_q <= '0;
        end else if (accept) begin
            left_q   <= centre_q;
            centre_q <= col_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else if (advance) begin
            s1.valid  <= in_valid;
            s1.border <= border_in;
            s1.d      <= lap_sum(left_q, centre_q, col_in);
        end
    end

    // R6
    window_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !advance |=> ($stable(left_q) && $stable(centre_q) && $stable(s1)));

endmodule

// File: rtl/mag_stage.sv
module mag_stage
    import lap_edge_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       advance,
    input  sum_stage_t s1,
    output logic       out_valid,
    output pix_t       out_pixel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pixel <= '0;
        end else if (advance) begin
            out_valid <= s1.valid;
            out_pixel <= s1.border ? '0 : mag_clamp(s1.d);
        end
    end

    // R5
    border_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && s1.valid && s1.border) |=> (out_pixel == '0));

    // R3
    clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && s1.valid && !s1.border && (s1.d > PIX_MAX || s1.d < PIX_MIN))
        |=> (out_pixel == {PIX_W{1'b1}}));

    // R4
    negative_mag_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && s1.valid && !s1.border && s1.d < 0) |=> (out_pixel != '0));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !advance) |=> (out_valid && $stable(out_pixel)));

endmodule

// File: rtl/lap_edge_top.sv
module lap_edge_top
    import lap_edge_pkg::*;
#(
    parameter int IMG_W = 720,
    parameter int IMG_H = 480
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_top,
    input  logic [7:0] in_mid,
    input  logic [7:0] in_bot,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_pixel
);
    logic       advance;
    logic       accept;
    logic       border;
    column_t    col_in;
    sum_stage_t s1;

    assign advance = !out_valid || out_ready;
    assign in_ready = advance;
    assign accept  = in_valid && advance;
    assign col_in  = '{top: in_top, mid: in_mid, bot: in_bot};

    raster_pos #(.W(IMG_W), .H(IMG_H)) u_pos (
        .clk    (clk),
        .rst    (rst),
        .step   (accept),
        .border (border)
    );

    lap_window u_win (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .advance   (advance),
        .col_in    (col_in),
        .border_in (border),
        .s1        (s1)
    );

    mag_stage u_mag (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance),
        .s1        (s1),
        .out_valid (out_valid),
        .out_pixel (out_pixel)
    );

    // R8
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R7
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) ##1 (!out_valid || out_ready) |=> out_valid);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && in_ready));

endmodule

// File: tb/lap_edge_top_test.sv
module lap_edge_top_test;
    localparam int TW   = 8;
    localparam int TH   = 5;
    localparam int NPIX = TW * TH;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_top = '0;
    logic [7:0] in_mid = '0;
    logic [7:0] in_bot = '0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_pixel;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    lap_edge_top #(.IMG_W(TW), .IMG_H(TH)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_top    (in_top),
        .in_mid    (in_mid),
        .in_bot    (in_bot),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_pixel (out_pixel)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pix(input int pat, input int x, input int y);
        case (pat)
            0:       return ((x * 37 + (y + 8) * 91 + 13) ^ (x * (y + 8) * 5)) & 255;
            1:       return 100;
            2:       return ((x + y + 16) % 2 != 0) ? 255 : 0;
            default: return ((x * 7 + (y + 8) * 11) % 23) * 3;
        endcase
    endfunction

    function automatic bit is_border(input int x, input int y);
        return (x < 2) || (y < 1) || (y > TH - 2);
    endfunction

    function automatic int exp_pix(input int pat, input int x, input int y);
        int c;
        int d;
        if (is_border(x, y)) return 0;
        c = x - 1;
        d = 4 * pix(pat, c, y) - pix(pat, c, y - 1) - pix(pat, c, y + 1)
            - pix(pat, c - 1, y) - pix(pat, c + 1, y);
        if (d < 0) d = -d;
        if (d > 255) d = 255;
        return d;
    endfunction

    task automatic drive_col(input int pat, input int i);
        int x;
        int y;
        x = i % TW;
        y = i / TW;
        in_top = 8'(pix(pat, x, y - 1));
        in_mid = 8'(pix(pat, x, y));
        in_bot = 8'(pix(pat, x, y + 1));
    endtask

    // mode 0: ready always, 1: ready two of three cycles, 2: ready one of five
    task automatic run_frame(input int pat, input int start, input int mode, input string req);
        int fed = start;
        int got = start;
        int cyc = 0;
        int e;
        bit prev_stall = 1'b0;
        logic [7:0] prev_pix = '0;
        while (got < NPIX && cyc < 20000) begin
            @(negedge clk);
            if (fed < NPIX) begin
                in_valid = 1'b1;
                drive_col(pat, fed);
            end else begin
                in_valid = 1'b0;
            end
            out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 3 != 1) : (cyc % 5 == 0);
            #1;
            if (prev_stall)
                check(out_valid === 1'b1 && out_pixel === prev_pix, "R8", int'(out_pixel), int'(prev_pix));
            if (out_valid && !out_ready)
                check(in_ready === 1'b0, "R8", int'(in_ready), 0);
            prev_stall = out_valid && !out_ready;
            prev_pix   = out_pixel;
            if (out_valid && out_ready) begin
                e = exp_pix(pat, got % TW, got / TW);
                check(int'(out_pixel) == e, is_border(got % TW, got / TW) ? "R5" : req,
                      int'(out_pixel), e);
                got++;
            end
            if (in_valid && in_ready) fed++;
            cyc++;
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        check(got == NPIX, "R6", got, NPIX);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(out_valid === 1'b0, "R1", int'(out_valid), 0);
        check(in_ready === 1'b1, "R1", int'(in_ready), 1);
    endtask

    task automatic test_latency();
        @(negedge clk);
        in_valid  = 1'b1;
        out_ready = 1'b1;
        drive_col(1, 0);
        #1;
        check(in_ready === 1'b1, "R7", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check(out_valid === 1'b0, "R7", int'(out_valid), 0);
        @(negedge clk);
        #1;
        check(out_valid === 1'b1, "R7", int'(out_valid), 1);
        check(out_pixel === 8'd0, "R5", int'(out_pixel), 0);
        run_frame(1, 1, 0, "R2");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog expired actual=hang expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_latency();
        run_frame(0, 0, 0, "R2");
        run_frame(0, 0, 0, "R9");
        run_frame(2, 0, 1, "R3");
        run_frame(3, 0, 2, "R4");
        run_frame(0, 0, 2, "R8");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule